// File: doc/BRIEF.md
# Exception Vector Dispatcher

This block sits between a processor core and the handler table in memory. Each cycle it looks at the synchronous exception causes the core raises and at the interrupt request lines from devices. It chooses one winner and issues a dispatch. The dispatch carries four things: the vector number, the class of the exception, the memory address of the handler-table entry for that vector, and the return address that the core must save.

The handler table has 256 entries and starts at a base address held in a register. Only supervisor-mode software can write that register. Each vector has a class, and the class decides which return address is saved:
- For a fault the core re-runs the instruction, so the saved address is the current PC.
- For a trap or an interrupt the saved address is the PC of the next instruction.
- An abort does not return, so no valid return address is saved.

A dispatch is a single-cycle pulse. The block then waits for an acknowledge before it issues another one.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, `disp_valid` and `ret_valid` are 0 and the table base is 0. A dispatch made before any base write therefore points at address `vector*4`.
- R2: The entry address is `base + vector*4`, taken modulo 2^AW. It uses the base value that is held in the cycle the cause is selected.
- R3: A base write with `sup_mode` high is stored at the clock edge. It applies to dispatches selected in later cycles, but not to a dispatch selected at that same edge.
- R4: A base write with `sup_mode` low is ignored, and the base keeps its old value.
- R5: Class encoding is abort=3, fault=2, trap=1, interrupt=0. A synchronous vector 18 is an abort. A synchronous vector from 0 to 31, other than 18, is a fault. A synchronous vector from 32 to 255 is a trap. Interrupt line i carries vector 32+i with class interrupt.
- R6: Between classes, the priority order is abort, then fault, then trap, then interrupt.
- R7: Within one class the lowest vector number wins. Synchronous slots whose valid bit is 0 are ignored, whatever vector they hold.
- R8: For a fault, `ret_pc` = `cur_pc` and `ret_valid` = 1. For a trap or an interrupt, `ret_pc` = `next_pc` and `ret_valid` = 1. For an abort, `ret_valid` = 0 and `ret_pc` = 0. The PCs used are the ones present in the cycle the cause is selected.
- R9: When the block is idle and a request is present at a clock edge, `disp_valid` rises after that edge, together with all dispatch fields. It stays high for exactly one cycle.
- R10: After a dispatch, no new dispatch is issued, even with requests held, until `disp_ack` is seen high at a clock edge. A held request is dispatched at the edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_valid | input | NSRC | One valid bit per synchronous cause slot |
| sync_vec | input | NSRC*8 | Vector of each slot; slot i is in bits [8i+7:8i] |
| irq | input | NIRQ | Interrupt request lines |
| cur_pc | input | AW | PC of the current instruction |
| next_pc | input | AW | PC of the next instruction |
| sup_mode | input | 1 | High when the core runs in supervisor mode |
| tbase_we | input | 1 | Table base write strobe |
| tbase_wdata | input | AW | New table base value |
| disp_ack | input | 1 | Acknowledge of the last dispatch |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_vec | output | 8 | Dispatched vector number |
| disp_class | output | 2 | Class of the dispatched vector |
| disp_addr | output | AW | Handler-table entry address |
| ret_pc | output | AW | Return address to save |
| ret_valid | output | 1 | The return address is meaningful |

## Verification
Every dispatch result is registered. Requests and PCs applied before clock edge k show up on the outputs just after edge k, so the bench drives its inputs at a falling edge and reads all fields at the next falling edge. The pulse must be gone one cycle after that, and the bench checks it at the falling edge that follows the acknowledge edge. A base write lands at the edge where it is strobed, so the bench checks its effect only on a dispatch selected at a later edge, and separately checks that a dispatch selected at the write edge still uses the old base.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] VEC_MACHINE_CHECK = 8'd18;
    localparam logic [VEC_W-1:0] VEC_FIRST_OS      = 8'd32;

    typedef enum logic [1:0] {
        CLS_INTR  = 2'd0,
        CLS_TRAP  = 2'd1,
        CLS_FAULT = 2'd2,
        CLS_ABORT = 2'd3
    } exc_cls_e;

    typedef struct packed {
        logic             hit;
        logic [VEC_W-1:0] vec;
        exc_cls_e         cls;
    } exc_cand_t;

    // class of a cause raised synchronously by the core
    function automatic exc_cls_e sync_class(input logic [VEC_W-1:0] v);
        if (v == VEC_MACHINE_CHECK) return CLS_ABORT;
        if (v < VEC_FIRST_OS)       return CLS_FAULT;
        return CLS_TRAP;
    endfunction

    // a beats b: higher class first, then lower vector
    function automatic logic outranks(input exc_cand_t a, input exc_cand_t b);
        if (!a.hit) return 1'b0;
        if (!b.hit) return 1'b1;
        if (a.cls != b.cls) return a.cls > b.cls;
        return a.vec < b.vec;
    endfunction

endpackage

// File: rtl/exc_sync_pick.sv
module exc_sync_pick
    import exc_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0]       valid,
    input  logic [NSRC*VEC_W-1:0] vecs,
    output exc_cand_t             best
);
    exc_cand_t cand [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        assign cand[g].hit = valid[g];
        assign cand[g].vec = vecs[g*VEC_W +: VEC_W];
        assign cand[g].cls = sync_class(vecs[g*VEC_W +: VEC_W]);
    end

    always_comb begin
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (outranks(cand[i], best)) best = cand[i];
        end
    end
endmodule

// File: rtl/exc_irq_pick.sv
module exc_irq_pick
    import exc_pkg::*;
#(
    parameter int NIRQ     = 8,
    parameter int IRQ_BASE = 32
) (
    input  logic [NIRQ-1:0] irq,
    output exc_cand_t       best
);
    always_comb begin
        best = '0;
        // scan downward so the lowest active line is kept
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (irq[i]) begin
                best.hit = 1'b1;
                best.vec = VEC_W'(IRQ_BASE + i);
                best.cls = CLS_INTR;
            end
        end
    end
endmodule

// File: rtl/exc_tbase.sv
module exc_tbase #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          sup,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (we && sup) q <= wdata;
    end

    p_user_write_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (we && !sup) |=> $stable(q));

    p_sup_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (we && sup) |=> (q == $past(wdata)));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int NSRC        = 4,
    parameter int NIRQ        = 8,
    parameter int AW          = 32,
    parameter int IRQ_BASE    = 32,
    parameter int ENTRY_LOG2  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       sync_valid,
    input  logic [NSRC*VEC_W-1:0] sync_vec,
    input  logic [NIRQ-1:0]       irq,
    input  logic [AW-1:0]         cur_pc,
    input  logic [AW-1:0]         next_pc,
    input  logic                  sup_mode,
    input  logic                  tbase_we,
    input  logic [AW-1:0]         tbase_wdata,
    input  logic                  disp_ack,
    output logic                  disp_valid,
    output logic [VEC_W-1:0]      disp_vec,
    output logic [1:0]            disp_class,
    output logic [AW-1:0]         disp_addr,
    output logic [AW-1:0]         ret_pc,
    output logic                  ret_valid
);
    exc_cand_t     sync_best, irq_best, win;
    logic [AW-1:0] tbase_q;
    logic [AW-1:0] entry_addr, sel_pc;
    logic          sel_pc_ok, busy, take;

    exc_sync_pick #(.NSRC(NSRC)) u_sync (
        .valid(sync_valid), .vecs(sync_vec), .best(sync_best)
    );

    exc_irq_pick #(.NIRQ(NIRQ), .IRQ_BASE(IRQ_BASE)) u_irq (
        .irq(irq), .best(irq_best)
    );

    exc_tbase #(.AW(AW)) u_tbase (
        .clk(clk), .rst(rst), .we(tbase_we), .sup(sup_mode),
        .wdata(tbase_wdata), .q(tbase_q)
    );

    always_comb begin
        win        = outranks(sync_best, irq_best) ? sync_best : irq_best;
        take       = win.hit && !busy;
        entry_addr = tbase_q + (AW'(win.vec) << ENTRY_LOG2);
        unique case (win.cls)
            CLS_FAULT: begin sel_pc = cur_pc;  sel_pc_ok = 1'b1; end
            CLS_ABORT: begin sel_pc = '0;      sel_pc_ok = 1'b0; end
            default:   begin sel_pc = next_pc; sel_pc_ok = 1'b1; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            disp_valid <= 1'b0;
            disp_vec   <= '0;
            disp_class <= '0;
            disp_addr  <= '0;
            ret_pc     <= '0;
            ret_valid  <= 1'b0;
        end else begin
            disp_valid <= take;
            if (take) begin
                busy       <= 1'b1;
                disp_vec   <= win.vec;
                disp_class <= win.cls;
                disp_addr  <= entry_addr;
                ret_pc     <= sel_pc;
                ret_valid  <= sel_pc_ok;
            end else if (disp_ack) begin
                busy <= 1'b0;
            end
        end
    end

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !disp_valid);

    p_wait_for_ack_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !disp_valid);

    p_abort_no_return_r8: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_class == CLS_ABORT) |-> !ret_valid);

    p_fault_reruns_r8: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_class == CLS_FAULT) |-> (ret_valid && ret_pc == $past(cur_pc)));

    p_entry_addr_r2: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_addr == $past(tbase_q) + (AW'(disp_vec) << ENTRY_LOG2)));

    p_machine_check_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_vec == VEC_MACHINE_CHECK && disp_class != CLS_INTR)
            |-> (disp_class == CLS_ABORT));
endmodule

// File: tb/exc_dispatch_tb.sv
module exc_dispatch_tb;
    localparam int NSRC = 4;
    localparam int NIRQ = 8;
    localparam int AW   = 32;
    localparam logic [31:0] CUR  = 32'h1000_0040;
    localparam logic [31:0] NEXT = 32'h1000_0044;

    typedef struct packed {
        logic [3:0]  sv;
        logic [31:0] vecs;
        logic [7:0]  irqs;
        logic [7:0]  evec;
        logic [1:0]  ecls;
    } case_t;

    // vecs = {slot3, slot2, slot1, slot0}
    localparam case_t CASES [8] = '{
        '{4'b0100, {8'd0,   8'd14,  8'd0,   8'd0  }, 8'h00, 8'd14,  2'd2},
        '{4'b0001, {8'd0,   8'd0,   8'd0,   8'd128}, 8'h08, 8'd128, 2'd1},
        '{4'b0000, 32'd0,                            8'h24, 8'd34,  2'd0},
        '{4'b1011, {8'd128, 8'd0,   8'd18,  8'd0  }, 8'h00, 8'd18,  2'd3},
        '{4'b1011, {8'd13,  8'd0,   8'd14,  8'd200}, 8'h00, 8'd13,  2'd2},
        '{4'b0110, {8'd5,   8'd200, 8'd129, 8'd0  }, 8'h00, 8'd129, 2'd1},
        '{4'b1000, 32'd0,                            8'hFF, 8'd0,   2'd2},
        '{4'b0000, 32'd0,                            8'h80, 8'd39,  2'd0}
    };

    logic clk = 1'b0;
    logic rst;
    logic [NSRC-1:0]   sync_valid;
    logic [NSRC*8-1:0] sync_vec;
    logic [NIRQ-1:0]   irq;
    logic [AW-1:0]     cur_pc, next_pc, tbase_wdata;
    logic sup_mode, tbase_we, disp_ack;
    logic disp_valid, ret_valid;
    logic [7:0]    disp_vec;
    logic [1:0]    disp_class;
    logic [AW-1:0] disp_addr, ret_pc;

    int total = 0;
    int bad   = 0;
    logic [31:0] base_model = 32'h0;

    always #4 clk = ~clk;

    exc_dispatch u_dut (
        .clk(clk), .rst(rst), .sync_valid(sync_valid), .sync_vec(sync_vec),
        .irq(irq), .cur_pc(cur_pc), .next_pc(next_pc), .sup_mode(sup_mode),
        .tbase_we(tbase_we), .tbase_wdata(tbase_wdata), .disp_ack(disp_ack),
        .disp_valid(disp_valid), .disp_vec(disp_vec), .disp_class(disp_class),
        .disp_addr(disp_addr), .ret_pc(ret_pc), .ret_valid(ret_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [31:0] vs, input logic [7:0] q);
        sync_valid = v;
        sync_vec   = vs;
        irq        = q;
    endtask

    // check every field of a dispatch expected on the outputs now
    task automatic chk_disp(input string tag, input logic [7:0] ev, input logic [1:0] ec);
        logic [31:0] epc;
        logic        erv;
        epc = (ec == 2'd2) ? CUR : ((ec == 2'd3) ? 32'h0 : NEXT);
        erv = (ec != 2'd3);
        chk({tag, " R9 valid"}, {31'd0, disp_valid}, 32'd1);
        chk({tag, " R7 vec"}, {24'd0, disp_vec}, {24'd0, ev});
        chk({tag, " R5 class"}, {30'd0, disp_class}, {30'd0, ec});
        chk({tag, " R2 addr"}, disp_addr, base_model + {22'd0, ev, 2'b00});
        chk({tag, " R8 retpc"}, ret_pc, epc);
        chk({tag, " R8 retvalid"}, {31'd0, ret_valid}, {31'd0, erv});
    endtask

    task automatic ack_and_clear(input string tag);
        drive(4'b0, 32'd0, 8'd0);
        disp_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        disp_ack = 1'b0;
        chk({tag, " R9 pulse ends"}, {31'd0, disp_valid}, 32'd0);
    endtask

    task automatic base_write(input logic sup, input logic [31:0] val);
        sup_mode    = sup;
        tbase_we    = 1'b1;
        tbase_wdata = val;
        @(posedge clk);
        @(negedge clk);
        tbase_we = 1'b0;
        sup_mode = 1'b0;
        if (sup) base_model = val;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(4'b0, 32'd0, 8'd0);
        cur_pc = CUR; next_pc = NEXT;
        sup_mode = 1'b0; tbase_we = 1'b0; tbase_wdata = '0; disp_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset valid", {31'd0, disp_valid}, 32'd0);
        chk("R1 reset retvalid", {31'd0, ret_valid}, 32'd0);

        // R1: base is 0 after reset
        drive(4'b0001, {24'd0, 8'd5}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        chk_disp("R1 base zero", 8'd5, 2'd2);
        ack_and_clear("R1");

        base_write(1'b1, 32'h0000_8000);
        // R4: user-mode write ignored
        base_write(1'b0, 32'hDEAD_0000);
        drive(4'b0, 32'd0, 8'h01);
        @(posedge clk);
        @(negedge clk);
        chk_disp("R4 user write ignored", 8'd32, 2'd0);
        ack_and_clear("R4");

        // R5 R6 R7 R8: vector table
        for (int k = 0; k < 8; k++) begin
            drive(CASES[k].sv, CASES[k].vecs, CASES[k].irqs);
            @(posedge clk);
            @(negedge clk);
            chk_disp($sformatf("R6 case%0d", k), CASES[k].evec, CASES[k].ecls);
            ack_and_clear("R6");
        end

        // R10: held request waits for ack
        drive(4'b0001, {24'd0, 8'd14}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        chk_disp("R10 first", 8'd14, 2'd2);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R10 no dispatch before ack", {31'd0, disp_valid}, 32'd0);
        end
        disp_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        disp_ack = 1'b0;
        chk("R10 not at ack edge", {31'd0, disp_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk_disp("R10 after ack", 8'd14, 2'd2);
        ack_and_clear("R10");

        // R2: address wraps modulo 2^AW
        base_write(1'b1, 32'hFFFF_FFF0);
        drive(4'b0001, {24'd0, 8'd200}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        chk_disp("R2 wrap", 8'd200, 2'd1);
        chk("R2 wrap value", disp_addr, 32'h0000_0310);
        ack_and_clear("R2");

        // R3: write at the selection edge does not apply to that dispatch
        sup_mode = 1'b1; tbase_we = 1'b1; tbase_wdata = 32'h0000_4000;
        drive(4'b0001, {24'd0, 8'd1}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        tbase_we = 1'b0; sup_mode = 1'b0;
        chk("R3 same-edge old base", disp_addr, 32'hFFFF_FFF4);
        ack_and_clear("R3");
        base_model = 32'h0000_4000;
        drive(4'b0001, {24'd0, 8'd1}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        chk_disp("R3 new base", 8'd1, 2'd2);
        ack_and_clear("R3");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule